// File: doc/BRIEF.md
# Programmable Byte Convolutional Deinterleaver

The block reverses convolutional interleaving on a stream of 204-byte transport frames. Arriving bytes are dealt in turn to I branches, where I is the interleaving depth. Branch j holds each byte for (I-1-j)·M visits of that branch, with M = 204/I. The last branch therefore passes its bytes straight through. The sum of the interleaver's delay and this block's delay is the same on every branch, so the original byte order comes back out. All branch delay lines share one on-chip byte memory. Each branch owns a contiguous region of that memory, used as a circular buffer, and the block computes one read/write address for each accepted byte.

The depth comes in on a configuration input that is sampled on every clock. The block accepts any divisor of 204 that is not above 12. A divisor of 204 above 12 needs an off-chip memory, which this block does not drive; the block only raises a flag for it. Any other value raises an error flag. In both cases the block keeps the current depth. A frame-sync marker on an input byte forces that byte onto branch 0. Output valid stays low until the delay lines hold real data.

Top module: `conv_deinterleaver`

## Requirements
- R1: The on-chip depths are the divisors of 204 that are not above 12: 1, 2, 3, 4, 6 and 12. A legal depth on depth_i that differs from the active depth becomes active at the next clock edge. At that edge the branch index, all branch pointers and the fill count are cleared, and any byte presented in that cycle is discarded, so out_valid_o is low in the following cycle. The depth after reset is 12.
- R2: After a clear, the first accepted byte goes to branch 0. Each byte with in_valid_i high advances the branch index by one, and the index wraps to 0 after branch I-1.
- R3: A byte accepted on branch j appears on out_data_o one cycle after the branch-j byte that was accepted (I-1-j)·(204/I) branch-j visits later. Bytes on branch I-1 therefore leave one cycle after they arrive.
- R4: A byte with in_valid_i and in_sync_i both high is placed on branch 0 whatever the current index is. The next byte goes to branch 1, or to branch 0 when I = 1.
- R5: The block is fed with a stream convolutionally interleaved at the same depth, where input byte k is taken from source byte k-(k mod I)·(204/I)·I. For that stream, every valid output byte n equals source byte n-(I-1)·(204/I)·I.
- R6: out_valid_o is high one cycle after an accepted byte, and only if at least I·(I-1)·(204/I) bytes were accepted between the last clear and that byte. Otherwise it is low.
- R7: A depth_i value that is 0, above 204, or not a divisor of 204 sets cfg_err_o in the next cycle. The active depth, pointers and data flow are not changed.
- R8: A divisor of 204 above 12 (17, 34, 51, 68, 102, 204) sets ext_mem_o in the next cycle, and the active configuration is kept. cfg_err_o and ext_mem_o are never high together.
- R9: While rst_ni is low, out_valid_o, cfg_err_o and ext_mem_o are low.
- R10: At depth 1 the block is a one-cycle byte delay, and out_valid_o follows in_valid_i at once with no fill period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Interleaved input byte |
| in_valid_i | input | 1 | Input byte valid |
| in_sync_i | input | 1 | Input byte is a frame sync byte |
| depth_i | input | 8 | Requested interleaving depth |
| out_data_o | output | 8 | Deinterleaved byte |
| out_valid_o | output | 1 | Output byte valid |
| cfg_err_o | output | 1 | Requested depth is not a divisor of 204 |
| ext_mem_o | output | 1 | Requested depth needs external memory |

## Verification
A wrong branch index shows at once when the affected byte lands on the pass-through branch. On the other branches it moves the byte to the wrong position in the frame, and the error appears one full branch delay later. A wrong region base or pointer wrap lets one branch read another branch's bytes. This shows on out_data_o when that slot is next read, at most (I-1)·M visits later. For that reason the streams run for well beyond the fill time at every legal depth. A clear that is missed or happens too early shifts the cycle in which out_valid_o first rises. That is compared cycle by cycle against the I·(I-1)·M count.

// File: rtl/cdi_pkg.sv
package cdi_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    CFG_ON_CHIP  = 2'd0,
    CFG_EXTERNAL = 2'd1,
    CFG_ILLEGAL  = 2'd2
  } cfg_kind_e;
endpackage

// File: rtl/cdi_cfg.sv
module cdi_cfg
  import cdi_pkg::*;
#(
  parameter int FRAME_LEN = 204,
  parameter int MAX_DEPTH = 12,
  parameter int DEF_DEPTH = 12,
  parameter int DEPTH_W   = 8,
  parameter int UNIT_W    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [DEPTH_W-1:0] depth_o,
  output logic [UNIT_W-1:0]  unit_o,
  output logic               clr_o,
  output logic               err_o,
  output logic               ext_o
);
  timeunit 1ns; timeprecision 1ps;

  function automatic cfg_kind_e classify(input logic [DEPTH_W-1:0] d);
    cfg_kind_e k;
    k = CFG_ILLEGAL;
    for (int c = 1; c <= FRAME_LEN; c++) begin
      if ((FRAME_LEN % c) == 0 && int'(d) == c)
        k = (c <= MAX_DEPTH) ? CFG_ON_CHIP : CFG_EXTERNAL;
    end
    return k;
  endfunction

  function automatic logic [UNIT_W-1:0] unit_of(input logic [DEPTH_W-1:0] d);
    logic [UNIT_W-1:0] u;
    u = '0;
    for (int c = 1; c <= MAX_DEPTH; c++) begin
      if ((FRAME_LEN % c) == 0 && int'(d) == c) u = UNIT_W'(FRAME_LEN / c);
    end
    return u;
  endfunction

  cfg_kind_e          kind;
  logic [DEPTH_W-1:0] depth_q;
  logic [UNIT_W-1:0]  unit_q;
  logic               err_q, ext_q;

  always_comb begin
    kind  = classify(depth_i);
    clr_o = (kind == CFG_ON_CHIP) && (depth_i != depth_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= DEPTH_W'(DEF_DEPTH);
      unit_q  <= UNIT_W'(FRAME_LEN / DEF_DEPTH);
      err_q   <= 1'b0;
      ext_q   <= 1'b0;
    end else begin
      err_q <= (kind == CFG_ILLEGAL);
      ext_q <= (kind == CFG_EXTERNAL);
      if (clr_o) begin
        depth_q <= depth_i;
        unit_q  <= unit_of(depth_i);
      end
    end
  end

  assign depth_o = depth_q;
  assign unit_o  = unit_q;
  assign err_o   = err_q;
  assign ext_o   = ext_q;

  AST_DEPTH_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    classify(depth_q) == CFG_ON_CHIP); // R1
  AST_HOLD_ON_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind != CFG_ON_CHIP) |=> $stable(depth_q) && $stable(unit_q)); // R7
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_o, ext_o})); // R8
endmodule

// File: rtl/cdi_branch.sv
module cdi_branch #(
  parameter int MAX_DEPTH = 12,
  parameter int DEPTH_W   = 8,
  parameter int UNIT_W    = 8,
  parameter int IDX_W     = 4,
  parameter int PTR_W     = 8,
  parameter int ADDR_W    = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               vld_i,
  input  logic               sync_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [UNIT_W-1:0]  unit_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               pass_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [IDX_W-1:0] idx_q, cur;
  logic [PTR_W-1:0] ptr_all [MAX_DEPTH];
  logic [PTR_W-1:0] ptr_cur, ptr_nxt;
  int               len, tri_n, base;
  logic             last;

  // branch j owns [unit*sum_{k<j}(I-1-k), +len) of the shared memory
  always_comb begin
    cur     = sync_i ? '0 : idx_q;
    len     = (int'(depth_i) - 1 - int'(cur)) * int'(unit_i);
    tri_n   = int'(cur) * (int'(depth_i) - 1) - (int'(cur) * (int'(cur) - 1)) / 2;
    base    = tri_n * int'(unit_i);
    ptr_cur = ptr_all[cur];
    ptr_nxt = (int'(ptr_cur) + 1 >= len) ? '0 : ptr_cur + 1'b1;
    addr_o  = ADDR_W'(base + int'(ptr_cur));
    pass_o  = (len <= 0);
    last    = (int'(cur) >= int'(depth_i) - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (vld_i) idx_q <= last ? '0 : cur + 1'b1;
  end

  for (genvar g = 0; g < MAX_DEPTH; g++) begin : g_ptr
    logic [PTR_W-1:0] p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    p_q <= '0;
      else if (clr_i) p_q <= '0;
      else if (vld_i && !pass_o && cur == IDX_W'(g)) p_q <= ptr_nxt;
    end
    assign ptr_all[g] = p_q;
  end

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_q) < int'(depth_i)); // R2
  AST_BRANCH_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i && last) |=> (idx_q == '0)); // R2
  AST_SYNC_BRANCH0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sync_i && !clr_i && depth_i > 1) |=> (idx_q == IDX_W'(1))); // R4
  AST_PTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !pass_o) |-> (int'(ptr_cur) < len)); // R3
endmodule

// File: rtl/cdi_ram.sv
module cdi_ram
  import cdi_pkg::*;
#(
  parameter int DEPTH  = 1122,
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             wdata_i,
  output byte_t             rdata_o
);
  timeunit 1ns; timeprecision 1ps;

  byte_t mem [DEPTH];
  byte_t rdata_q;

  // read-first: the slot's old byte leaves as the new one lands
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      rdata_q      <= mem[addr_i];
      mem[addr_i]  <= wdata_i;
    end
  end

  assign rdata_o = rdata_q;

  AST_ADDR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (int'(addr_i) < DEPTH)); // R3
endmodule

// File: rtl/cdi_fill.sv
module cdi_fill #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic [CNT_W-1:0] tgt_i,
  output logic             full_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (acc_i && cnt_q != tgt_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q >= tgt_i);

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= tgt_i); // R6
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/conv_deinterleaver.sv
module conv_deinterleaver
  import cdi_pkg::*;
#(
  parameter  int FRAME_LEN = 204,
  parameter  int MAX_DEPTH = 12,
  parameter  int DEF_DEPTH = 12,
  localparam int DEPTH_W   = $clog2(FRAME_LEN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         in_data_i,
  input  logic               in_valid_i,
  input  logic               in_sync_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [7:0]         out_data_o,
  output logic               out_valid_o,
  output logic               cfg_err_o,
  output logic               ext_mem_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int UNIT_W    = $clog2(FRAME_LEN + 1);
  localparam int IDX_W     = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;
  localparam int PTR_W     = $clog2(FRAME_LEN);
  localparam int RAM_DEPTH = (FRAME_LEN * (MAX_DEPTH - 1)) / 2;
  localparam int ADDR_W    = $clog2(RAM_DEPTH);
  localparam int CNT_W     = $clog2(FRAME_LEN * (MAX_DEPTH - 1) + 1);

  logic [DEPTH_W-1:0] depth;
  logic [UNIT_W-1:0]  unit;
  logic               clr, acc, pass, full;
  logic [ADDR_W-1:0]  addr;
  logic [CNT_W-1:0]   fill_tgt;
  byte_t              rd_data, din_q;
  logic               vld_q, pass_q;

  cdi_cfg #(
    .FRAME_LEN(FRAME_LEN), .MAX_DEPTH(MAX_DEPTH), .DEF_DEPTH(DEF_DEPTH),
    .DEPTH_W(DEPTH_W), .UNIT_W(UNIT_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .depth_i(depth_i),
    .depth_o(depth), .unit_o(unit), .clr_o(clr),
    .err_o(cfg_err_o), .ext_o(ext_mem_o)
  );

  assign acc      = in_valid_i && !clr;
  assign fill_tgt = CNT_W'(int'(unit) * int'(depth) * (int'(depth) - 1));

  cdi_branch #(
    .MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W), .UNIT_W(UNIT_W),
    .IDX_W(IDX_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W)
  ) u_branch (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .vld_i(acc),
    .sync_i(in_sync_i), .depth_i(depth), .unit_i(unit),
    .addr_o(addr), .pass_o(pass)
  );

  cdi_ram #(.DEPTH(RAM_DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(acc && !pass),
    .addr_i(addr), .wdata_i(in_data_i), .rdata_o(rd_data)
  );

  cdi_fill #(.CNT_W(CNT_W)) u_fill (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .acc_i(acc),
    .tgt_i(fill_tgt), .full_o(full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      pass_q <= 1'b0;
      din_q  <= '0;
    end else begin
      vld_q  <= acc && full;
      pass_q <= pass;
      din_q  <= in_data_i;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = pass_q ? din_q : rd_data;

  AST_QUIET_AFTER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !out_valid_o); // R1
  AST_VALID_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R6
  AST_PASS_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth == 1 && in_valid_i && !clr) |=> (out_valid_o && out_data_o == $past(in_data_i))); // R10
endmodule

// File: tb/conv_deinterleaver_tb.sv
module conv_deinterleaver_tb;
  timeunit 1ns; timeprecision 1ps;

  localparam int FL = 204;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_sync = 1'b0;
  logic [7:0] depth = 8'd12;
  logic [7:0] out_data;
  logic       out_valid, cfg_err, ext_mem;

  always #2.5 clk = ~clk; // 200 MHz

  conv_deinterleaver u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_sync_i(in_sync), .depth_i(depth), .out_data_o(out_data),
    .out_valid_o(out_valid), .cfg_err_o(cfg_err), .ext_mem_o(ext_mem)
  );

  int n_chk = 0, n_fail = 0;
  int cur_i = 12, cur_m = 17, nacc = 0, br = 0;
  int bq [12][$];
  int exp_vld = 0, exp_dat = -1, exp_e2e = -1, exp_err = 0, exp_ext = 0;
  int e2e_on = 0;
  int rnd = 7;
  string vtag = "R6", dtag = "R2/R3";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int src(input int k);
    return (k % FL == 0) ? 8'h47 : ((k * 37 + 11) & 255);
  endfunction

  // matching interleaver: branch j delays by j*M visits
  function automatic int ilv(input int k);
    int d = (k % cur_i) * cur_m * cur_i;
    return (k >= d) ? src(k - d) : 0;
  endfunction

  function automatic int kind(input int d);
    if (d >= 1 && d <= FL && FL % d == 0) return (d <= 12) ? 0 : 1;
    return 2;
  endfunction

  function automatic int next_rnd();
    rnd = rnd * 1103515245 + 12345;
    return (rnd >>> 8) & 255;
  endfunction

  task automatic compare();
    chk(out_valid === exp_vld[0], vtag, int'(out_valid), exp_vld);
    vtag = "R6";
    if (exp_vld != 0 && exp_dat >= 0) chk(int'(out_data) == exp_dat, dtag, int'(out_data), exp_dat);
    if (exp_vld != 0 && exp_e2e >= 0) chk(int'(out_data) == exp_e2e, "R5", int'(out_data), exp_e2e);
    chk(cfg_err === exp_err[0], "R7", int'(cfg_err), exp_err);
    chk(ext_mem === exp_ext[0], "R8", int'(ext_mem), exp_ext);
  endtask

  task automatic model_clear(input int d);
    cur_i = d; cur_m = FL / d; nacc = 0; br = 0;
    for (int b = 0; b < 12; b++) bq[b].delete();
  endtask

  task automatic step(input bit v, input int d, input bit sy);
    @(negedge clk);
    compare();
    in_valid = v; in_data = 8'(d); in_sync = sy;
    exp_vld = 0; exp_dat = -1; exp_e2e = -1;
    if (v) begin
      int j = sy ? 0 : br;
      int len = (cur_i - 1 - j) * cur_m;
      int tot = (cur_i - 1) * cur_m * cur_i;
      bq[j].push_back(d & 255);
      if (bq[j].size() > len) exp_dat = bq[j].pop_front();
      exp_vld = (nacc >= tot) ? 1 : 0;
      if (e2e_on != 0 && nacc >= tot) exp_e2e = src(nacc - tot);
      nacc++;
      br = (j == cur_i - 1) ? 0 : j + 1;
    end
  endtask

  task automatic set_depth(input int d);
    int k = kind(d);
    @(negedge clk);
    compare();
    depth = 8'(d); in_valid = 1'b0; in_sync = 1'b0;
    exp_vld = 0; exp_dat = -1; exp_e2e = -1;
    exp_err = (k == 2) ? 1 : 0;
    exp_ext = (k == 1) ? 1 : 0;
    if (k == 0 && d != cur_i) begin
      model_clear(d);
      vtag = "R1";
    end
  endtask

  task automatic run_e2e(input int nbytes);
    e2e_on = 1; dtag = "R2/R3";
    for (int k = 0; k < nbytes; k++) begin
      if (k % 9 == 8) step(1'b0, 0, 1'b0);
      step(1'b1, ilv(k), (k % FL) == 0);
    end
    e2e_on = 0;
  endtask

  task automatic run_rand(input int n);
    for (int i = 0; i < n; i++) step(1'b1, next_rnd(), 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
    chk(cfg_err == 1'b0, "R9", int'(cfg_err), 0);
    chk(ext_mem == 1'b0, "R9", int'(ext_mem), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // default depth 12, full fill then steady state
    run_e2e(2244 + 400);

    // rejected depths keep depth 12 running
    set_depth(5);   run_rand(40);
    set_depth(17);  run_rand(40);
    set_depth(0);   run_rand(40);
    set_depth(204); run_rand(20);
    set_depth(200); run_rand(20);

    set_depth(4); run_e2e(612 + 300);
    set_depth(3); run_e2e(408 + 300);

    // misaligned sync forces branch 0
    dtag = "R4";
    run_rand(10);
    while (br != 1) step(1'b1, next_rnd(), 1'b0);
    step(1'b1, next_rnd(), 1'b1);
    run_rand(30);
    while (br != 2) step(1'b1, next_rnd(), 1'b0);
    step(1'b1, next_rnd(), 1'b1);
    run_rand(500);

    set_depth(2); run_e2e(204 + 300);
    set_depth(6); run_e2e(1020 + 300);

    set_depth(1);
    dtag = "R10";
    run_rand(60);
    step(1'b0, 0, 1'b0);
    run_rand(20);
    dtag = "R2/R3";

    // re-select same depth: no clear
    set_depth(1); run_rand(10);

    set_depth(12); run_rand(100);

    // reset in mid stream
    @(negedge clk);
    compare();
    rst_n = 1'b0; in_valid = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
    chk(cfg_err == 1'b0, "R9", int'(cfg_err), 0);
    chk(ext_mem == 1'b0, "R9", int'(ext_mem), 0);
    model_clear(12);
    exp_vld = 0; exp_dat = -1; exp_e2e = -1; exp_err = 0; exp_ext = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_e2e(2244 + 100);
    step(1'b0, 0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule